// File: doc/BRIEF.md
# Time-Multiplexed FIR Address and Strobe Sequencer

This block produces all the timing for a FIR filter engine that shares one multiply-accumulate path across every tap. A frame lasts 2^ADDR_W system clocks (256 by default), and each frame yields one filter output. A free-running frame counter supplies the coefficient read address directly. The sample delay line is built as a ring, so a new sample does not land at a fixed slot. For that reason, the sample read address is the counter plus an offset that moves forward by one slot each frame.

The block also drives the following signals:
- a sample write address that trails the read address by one clock, so each word read is written back one position further along the cascade;
- a one-clock sample write enable per frame;
- a slow sample clock with a period of one frame;
- two delayed copies of the write enable, which clear the accumulator and latch the finished sum.

Both delays equal the coefficient RAM read latency plus the multiplier pipeline depth. The latch therefore catches the sum of the last product of a frame in the same cycle that the clear reloads the accumulator with the first product of the next frame. The memories and the arithmetic sit outside this block.

Top module: `fir_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and in the first cycle after it falls, the outputs are: `coef_rd_addr`, `smp_rd_addr` and `smp_wr_addr` all 0; `smp_wr_en` 1; `smp_clk` 1; `acc_clear` 0; `res_strobe` 0.
- R2: `coef_rd_addr` equals n mod 256, where n is the number of clocks since reset was released.
- R3: `smp_rd_addr` equals (n mod 256 + floor(n/256)) mod 256. In other words, the frame offset advances by one per frame, so the read address steps by 2 across each frame boundary and by 1 at all other times.
- R4: `smp_wr_addr` equals the value `smp_rd_addr` had one clock earlier, and is 0 in cycle n = 0.
- R5: `smp_wr_en` is 1 exactly in the cycles where `coef_rd_addr` is 0, which is once per 256 clocks.
- R6: `smp_clk` is 1 while `coef_rd_addr` is below 128 and 0 from 128 to 255. Its period is therefore 256 clocks, and it rises with `smp_wr_en`.
- R7: `acc_clear` is `smp_wr_en` delayed by RD_LAT+MUL_LAT clocks (3 by default). It is therefore 1 exactly when `coef_rd_addr` is 3.
- R8: `res_strobe` is `smp_wr_en` delayed by RD_LAT+MUL_LAT clocks, which is the same cycle as `acc_clear`.
- R9: The frame offset wraps modulo 256. In frame 256 (n from 65536 to 65791), `smp_rd_addr` equals `coef_rd_addr` again.
- R10: Raising `rst` in the middle of a run returns every output to its R1 value. The sequence then restarts from n = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_rd_addr | output | ADDR_W | Rotating read address of the sample delay line |
| smp_wr_addr | output | ADDR_W | Sample write address, read address one clock late |
| coef_rd_addr | output | ADDR_W | Coefficient read address, the frame counter |
| smp_wr_en | output | 1 | One-clock-per-frame sample write enable |
| smp_clk | output | 1 | Sample-rate clock, high for the first half of a frame |
| acc_clear | output | 1 | Accumulator clear, delayed write enable |
| res_strobe | output | 1 | Result latch strobe, delayed write enable |

## Verification
On every clock, the assertions check four local relations:
- the counter step;
- the +1/+2 step of the sample read address;
- the one-clock lag of the write address;
- the decoding of the write enable, the sample clock and both delayed strobes from the counter phase.

Only the bench's scenarios show the long-range behaviour. This covers the absolute value of the frame offset after many frames, its modulo-256 wrap after 65536 clocks, the exact values held during and right after reset, and the restart from a mid-run reset.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;
  // default address width: one frame is 2**FSQ_ADDR_W clocks
  localparam int unsigned FSQ_ADDR_W  = 8;
  // default RAM read latency and multiplier pipeline depth
  localparam int unsigned FSQ_RD_LAT  = 1;
  localparam int unsigned FSQ_MUL_LAT = 2;
endpackage

// File: rtl/fir_seq_frame_ctr.sv
module fir_seq_frame_ctr #(
  parameter int unsigned ADDR_W = fir_seq_pkg::FSQ_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] cnt,
  output logic              frame_end,
  output logic              wr_en,
  output logic              slow_clk
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] HALF = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [ADDR_W-1:0] cnt_nxt;

  assign cnt_nxt   = cnt + 1'b1;
  assign frame_end = (cnt == LAST);

  // outputs are registered from the next counter value, so they align with cnt
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      wr_en    <= 1'b1;
      slow_clk <= 1'b1;
    end else begin
      cnt      <= cnt_nxt;
      wr_en    <= (cnt_nxt == '0);
      slow_clk <= ~cnt_nxt[ADDR_W-1];
    end
  end

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == $past(cnt) + 1'b1)
    else $error("counter did not step by one");

  p_wr_en_phase_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en == (cnt == '0))
    else $error("write enable off its phase");

  p_slow_clk_half_r6: assert property (@(posedge clk) disable iff (rst)
    slow_clk == (cnt < HALF))
    else $error("sample clock off its phase");
endmodule

// File: rtl/fir_seq_rot_addr.sv
module fir_seq_rot_addr #(
  parameter int unsigned ADDR_W = fir_seq_pkg::FSQ_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr
);
  logic [ADDR_W-1:0] step;

  // counter +1 and offset +1 at a frame boundary add up to a step of two
  assign step = frame_end ? ADDR_W'(2) : ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr <= '0;
      wr_addr <= '0;
    end else begin
      rd_addr <= rd_addr + step;
      wr_addr <= rd_addr;
    end
  end

  p_rd_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_addr == $past(rd_addr) + ($past(frame_end) ? ADDR_W'(2) : ADDR_W'(1)))
    else $error("read address step wrong");

  p_wr_lag_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wr_addr == $past(rd_addr))
    else $error("write address not one clock behind");
endmodule

// File: rtl/fir_seq_pulse_dly.sv
module fir_seq_pulse_dly #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (DEPTH == 0) begin : g_thru
      assign dout = din;
    end else begin : g_shift
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2 >= 0 ? DEPTH-2 : 0 : 0], din} & {DEPTH{1'b1}};
      end
      assign dout = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fir_addr_seq.sv
module fir_addr_seq #(
  parameter int unsigned ADDR_W  = fir_seq_pkg::FSQ_ADDR_W,
  parameter int unsigned RD_LAT  = fir_seq_pkg::FSQ_RD_LAT,
  parameter int unsigned MUL_LAT = fir_seq_pkg::FSQ_MUL_LAT
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] smp_rd_addr,
  output logic [ADDR_W-1:0] smp_wr_addr,
  output logic [ADDR_W-1:0] coef_rd_addr,
  output logic              smp_wr_en,
  output logic              smp_clk,
  output logic              acc_clear,
  output logic              res_strobe
);
  localparam int unsigned FRAME     = 1 << ADDR_W;
  localparam int unsigned CLR_DLY   = RD_LAT + MUL_LAT;
  // accumulator still holds the full sum in the cycle it is cleared
  localparam int unsigned LATCH_DLY = RD_LAT + MUL_LAT;
  localparam logic [ADDR_W-1:0] CLR_POS   = ADDR_W'(CLR_DLY % FRAME);
  localparam logic [ADDR_W-1:0] LATCH_POS = ADDR_W'(LATCH_DLY % FRAME);

  logic frame_end;

  fir_seq_frame_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .cnt       (coef_rd_addr),
    .frame_end (frame_end),
    .wr_en     (smp_wr_en),
    .slow_clk  (smp_clk)
  );

  fir_seq_rot_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end),
    .rd_addr   (smp_rd_addr),
    .wr_addr   (smp_wr_addr)
  );

  fir_seq_pulse_dly #(.DEPTH(CLR_DLY)) u_clr_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (smp_wr_en),
    .dout (acc_clear)
  );

  fir_seq_pulse_dly #(.DEPTH(LATCH_DLY)) u_latch_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (smp_wr_en),
    .dout (res_strobe)
  );

  p_clr_phase_r7: assert property (@(posedge clk) disable iff (rst)
    acc_clear == (coef_rd_addr == CLR_POS))
    else $error("accumulator clear off its phase");

  p_latch_phase_r8: assert property (@(posedge clk) disable iff (rst)
    res_strobe == (coef_rd_addr == LATCH_POS))
    else $error("result strobe off its phase");

  p_wr_clk_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(smp_clk) |-> smp_wr_en)
    else $error("sample clock rose without write enable");
endmodule

// File: tb/test_fir_addr_seq.sv
module test_fir_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FR  = 256;
  localparam int DLY = 3;
  localparam int NVEC = 24;
  localparam int unsigned VEC [NVEC] = '{
    0, 1, 2, 3, 4, 5, 127, 128, 200, 254, 255, 256,
    257, 258, 259, 383, 384, 511, 512, 1000, 65535, 65536, 65537, 65539 };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] smp_rd_addr, smp_wr_addr, coef_rd_addr;
  logic smp_wr_en, smp_clk, acc_clear, res_strobe;
  int unsigned n;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  fir_addr_seq i_fir_addr_seq (
    .clk          (clk),
    .rst          (rst),
    .smp_rd_addr  (smp_rd_addr),
    .smp_wr_addr  (smp_wr_addr),
    .coef_rd_addr (coef_rd_addr),
    .smp_wr_en    (smp_wr_en),
    .smp_clk      (smp_clk),
    .acc_clear    (acc_clear),
    .res_strobe   (res_strobe)
  );

  function automatic int rd_of(input int unsigned k);
    return int'(((k % FR) + ((k / FR) % FR)) % FR);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at n=%0d: actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  task automatic chk_reset_vals(input string tag);
    chk({tag, " coef"}, int'(coef_rd_addr), 0);
    chk({tag, " rd"},   int'(smp_rd_addr), 0);
    chk({tag, " wr"},   int'(smp_wr_addr), 0);
    chk({tag, " wren"}, int'(smp_wr_en), 1);
    chk({tag, " sclk"}, int'(smp_clk), 1);
    chk({tag, " clr"},  int'(acc_clear), 0);
    chk({tag, " lat"},  int'(res_strobe), 0);
  endtask

  task automatic chk_cycle();
    int unsigned c;
    c = n % FR;
    chk("R2 coef_rd_addr", int'(coef_rd_addr), int'(c));
    chk((n >= 65536) ? "R9 smp_rd_addr wrap" : "R3 smp_rd_addr", int'(smp_rd_addr), rd_of(n));
    chk("R4 smp_wr_addr", int'(smp_wr_addr), (n == 0) ? 0 : rd_of(n - 1));
    chk("R5 smp_wr_en", int'(smp_wr_en), (c == 0) ? 1 : 0);
    chk("R6 smp_clk", int'(smp_clk), (c < FR/2) ? 1 : 0);
    chk("R7 acc_clear", int'(acc_clear), (c == DLY) ? 1 : 0);
    chk("R8 res_strobe", int'(res_strobe), (c == DLY) ? 1 : 0);
  endtask

  task automatic goto(input int unsigned tgt);
    while (n != tgt) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_vals("R1 in reset");
    rst = 1'b0;
    chk_reset_vals("R1 first cycle");
    for (int i = 0; i < NVEC; i++) begin
      goto(VEC[i]);
      chk_cycle();
    end
    // mid-run reset, R10
    goto(70000);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_reset_vals("R10 in reset");
    rst = 1'b0;
    chk_reset_vals("R10 first cycle");
    for (int k = 0; k < 6; k++) begin
      goto(k);
      chk_cycle();
    end
    goto(FR + 1);
    chk_cycle();
    finish_up();
  end
endmodule